// File: doc/BRIEF.md
# Debug Breakpoint Register Bank

This block holds the configuration of a small hardware breakpoint unit and evaluates its match conditions every cycle. Two agents can write the configuration. An external debug host sends read-register and write-register commands. Each command selects a register through a 5-bit index and moves a full 32-bit word. The on-chip processor can also write the breakpoint registers through a supervisor-only write strobe. The host owns a lock bit in the control/status register. While the lock is set, every processor write is discarded. Host commands are never blocked.

The bank contains a trigger-enable register, a lower and an upper operand-address bound, an attribute register that packs a match value and a don't-care mask, a register of program-counter valid bits, and `NUM_PC` program-counter breakpoint registers. Three registered comparators produce a range hit, an attribute hit and a program-counter hit. Each hit is evaluated against the current register contents and the cycle's address, attribute and program-counter inputs, and appears one cycle later.

Register indices: 0 control/status (bit 0 = lock), 1 trigger enable (bit 0 = range, bit 1 = attribute), 2 lower bound, 3 upper bound, 4 attribute (match in bits [ATTR_W-1:0], mask in bits [16+ATTR_W-1:16]), 7 program-counter valid bits (bit i belongs to breakpoint i), 8+i program-counter breakpoint i.

Top module: `dbg_bkpt_bank`

## Requirements
- R1: Every host command accepted in cycle t produces exactly one response (`host_rsp_valid` high) in cycle t+1; a host read returns the addressed register, and a host write to an implemented register changes its contents from cycle t+1.
- R2: The response to a host write carries the 17-bit completion status 0x0FFFF, zero-extended to 32 bits (0x0000FFFF).
- R3: Bits that a register does not implement read as zero, indices with no register read as zero, and writes to such indices change nothing.
- R4: A processor write with `cpu_supervisor` high and the lock clear updates the addressed breakpoint register (indices 1 to 4, 7, 8+i) in the next cycle.
- R5: A processor write is ignored when the lock (index 0, bit 0) is set or when `cpu_supervisor` is low; the processor can never change the control/status register.
- R6: When the host and the processor write the same register in the same cycle, the host value is stored.
- R7: `range_hit` is high in cycle t+1 exactly when in cycle t the range enable (index 1, bit 0) is set and lower <= `op_addr` <= upper, compared unsigned.
- R8: `attr_hit` is high in cycle t+1 exactly when in cycle t the attribute enable (index 1, bit 1) is set and ((`op_attr` XOR match) AND NOT mask) is zero; a mask bit of 1 is don't-care.
- R9: `pc_hit_vec[i]` is high in cycle t+1 exactly when in cycle t valid bit i is set and `pc` equals breakpoint i; `pc_hit` is the OR of the vector.
- R10: After reset every register is zero, no hit is asserted and no response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_valid | input | 1 | Host command present this cycle |
| host_cmd_write | input | 1 | 1 = write-register, 0 = read-register |
| host_cmd_idx | input | 5 | Host register index |
| host_cmd_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | Response to last cycle's host command |
| host_rsp_data | output | 32 | Read data or write completion status |
| cpu_wr_en | input | 1 | Processor debug-write strobe |
| cpu_supervisor | input | 1 | Processor is in supervisor mode |
| cpu_wr_idx | input | 5 | Processor register index |
| cpu_wr_data | input | 32 | Processor write data |
| op_addr | input | 32 | Core operand address |
| op_attr | input | ATTR_W | Core address attributes |
| pc | input | 32 | Core program counter |
| range_hit | output | 1 | Operand address inside enabled range |
| attr_hit | output | 1 | Attributes match under mask |
| pc_hit | output | 1 | Any valid program-counter breakpoint matched |
| pc_hit_vec | output | NUM_PC | Per-breakpoint program-counter match |

## Verification
The assertions check on every cycle that each host command gets exactly one response in the next cycle, and that every write response carries the completion status. They check that a locked processor write with no host write leaves the whole bank unchanged, and that no hit appears unless its enable or valid bit was set. They also check that reset leaves all outputs quiet. Only the bench scenarios can show that the data read back matches the value written under each register's implemented bit mask, and that host writes win collisions. The same holds for the exact hit boundaries: the edges of the range, every attribute value under a partial mask, and every combination of program-counter valid bits.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

    localparam int IDX_W  = 5;
    localparam int DATA_W = 32;

    // Register index map
    localparam logic [IDX_W-1:0] IDX_CSR  = 5'd0;
    localparam logic [IDX_W-1:0] IDX_TEN  = 5'd1;
    localparam logic [IDX_W-1:0] IDX_LO   = 5'd2;
    localparam logic [IDX_W-1:0] IDX_HI   = 5'd3;
    localparam logic [IDX_W-1:0] IDX_ATTR = 5'd4;
    localparam logic [IDX_W-1:0] IDX_PCV  = 5'd7;
    localparam logic [IDX_W-1:0] IDX_PBR0 = 5'd8;

    // Bit position of the mask field inside the attribute register
    localparam int ATTR_MASK_LSB = 16;

    // Status returned once a host write has been applied
    localparam logic [16:0] WR_DONE = 17'h0FFFF;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

endpackage

// File: rtl/dbg_host_port.sv
module dbg_host_port
    import dbg_bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output wr_req_t           host_wr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rd_idx        = cmd_idx;
        host_wr.valid = cmd_valid && cmd_write;
        host_wr.idx   = cmd_idx;
        host_wr.data  = cmd_wdata;

        rsp_d.valid = cmd_valid;
        rsp_d.data  = '0;
        if (cmd_valid) begin
            if (cmd_write) begin
                rsp_d.data = {{(DATA_W-17){1'b0}}, WR_DONE};
            end else begin
                rsp_d.data = rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = rsp_q.data;

endmodule

// File: rtl/dbg_cpu_port.sv
module dbg_cpu_port
    import dbg_bkpt_pkg::*;
(
    input  logic              wr_en,
    input  logic              supervisor,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock,
    output wr_req_t           cpu_wr
);

    logic allowed;

    always_comb begin
        // The processor may touch breakpoint registers only: never the
        // control/status word, never in user mode, never while locked.
        allowed      = supervisor && !lock && (wr_idx != IDX_CSR);
        cpu_wr.valid = wr_en && allowed;
        cpu_wr.idx   = wr_idx;
        cpu_wr.data  = wr_data;
    end

endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file
    import dbg_bkpt_pkg::*;
#(
    parameter int NUM_PC = 4,
    parameter int ATTR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  wr_req_t                  host_wr,
    input  wr_req_t                  cpu_wr,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     lock,
    output logic                     range_en,
    output logic                     attr_en,
    output logic [DATA_W-1:0]        lo_bound,
    output logic [DATA_W-1:0]        hi_bound,
    output logic [ATTR_W-1:0]        attr_match,
    output logic [ATTR_W-1:0]        attr_mask,
    output logic [NUM_PC-1:0]        pc_valid,
    output logic [NUM_PC*DATA_W-1:0] pc_bkpt
);

    localparam int MASK_MSB = ATTR_MASK_LSB + ATTR_W - 1;

    typedef struct packed {
        logic                           lock;
        logic                           range_en;
        logic                           attr_en;
        logic [DATA_W-1:0]              lo;
        logic [DATA_W-1:0]              hi;
        logic [ATTR_W-1:0]              amatch;
        logic [ATTR_W-1:0]              amask;
        logic [NUM_PC-1:0]              pcv;
        logic [NUM_PC-1:0][DATA_W-1:0]  pbr;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic bank_t apply_wr(bank_t b, wr_req_t w);
        bank_t r;
        r = b;
        if (w.valid) begin
            if (w.idx == IDX_CSR)  r.lock     = w.data[0];
            if (w.idx == IDX_TEN) begin
                r.range_en = w.data[0];
                r.attr_en  = w.data[1];
            end
            if (w.idx == IDX_LO)   r.lo       = w.data;
            if (w.idx == IDX_HI)   r.hi       = w.data;
            if (w.idx == IDX_ATTR) begin
                r.amatch = w.data[ATTR_W-1:0];
                r.amask  = w.data[MASK_MSB:ATTR_MASK_LSB];
            end
            if (w.idx == IDX_PCV)  r.pcv      = w.data[NUM_PC-1:0];
            for (int i = 0; i < NUM_PC; i++) begin
                if (w.idx == IDX_PBR0 + IDX_W'(i)) r.pbr[i] = w.data;
            end
        end
        return r;
    endfunction

    always_comb begin
        // Processor write first, host write on top: host wins a collision
        bank_d = apply_wr(apply_wr(bank_q, cpu_wr), host_wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // Read mux: unimplemented bits and unmapped indices give zero
    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_CSR)  rd_data[0] = bank_q.lock;
        if (rd_idx == IDX_TEN)  rd_data[1:0] = {bank_q.attr_en, bank_q.range_en};
        if (rd_idx == IDX_LO)   rd_data = bank_q.lo;
        if (rd_idx == IDX_HI)   rd_data = bank_q.hi;
        if (rd_idx == IDX_ATTR) begin
            rd_data[ATTR_W-1:0]           = bank_q.amatch;
            rd_data[MASK_MSB:ATTR_MASK_LSB] = bank_q.amask;
        end
        if (rd_idx == IDX_PCV)  rd_data[NUM_PC-1:0] = bank_q.pcv;
        for (int i = 0; i < NUM_PC; i++) begin
            if (rd_idx == IDX_PBR0 + IDX_W'(i)) rd_data = bank_q.pbr[i];
        end
    end

    assign lock       = bank_q.lock;
    assign range_en   = bank_q.range_en;
    assign attr_en    = bank_q.attr_en;
    assign lo_bound   = bank_q.lo;
    assign hi_bound   = bank_q.hi;
    assign attr_match = bank_q.amatch;
    assign attr_mask  = bank_q.amask;
    assign pc_valid   = bank_q.pcv;
    assign pc_bkpt    = bank_q.pbr;

endmodule

// File: rtl/dbg_match.sv
module dbg_match
    import dbg_bkpt_pkg::*;
#(
    parameter int NUM_PC = 4,
    parameter int ATTR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     range_en,
    input  logic                     attr_en,
    input  logic [DATA_W-1:0]        lo_bound,
    input  logic [DATA_W-1:0]        hi_bound,
    input  logic [ATTR_W-1:0]        attr_match,
    input  logic [ATTR_W-1:0]        attr_mask,
    input  logic [NUM_PC-1:0]        pc_valid,
    input  logic [NUM_PC*DATA_W-1:0] pc_bkpt,
    input  logic [DATA_W-1:0]        op_addr,
    input  logic [ATTR_W-1:0]        op_attr,
    input  logic [DATA_W-1:0]        pc,
    output logic                     range_hit,
    output logic                     attr_hit,
    output logic [NUM_PC-1:0]        pc_hit_vec
);

    typedef struct packed {
        logic              range;
        logic              attr;
        logic [NUM_PC-1:0] pcm;
    } hit_t;

    hit_t hit_d, hit_q;
    logic [NUM_PC-1:0] pc_eq;

    for (genvar g = 0; g < NUM_PC; g++) begin : g_pc_cmp
        assign pc_eq[g] = pc_valid[g] && (pc == pc_bkpt[g*DATA_W +: DATA_W]);
    end

    always_comb begin
        hit_d.range = range_en && (op_addr >= lo_bound) && (op_addr <= hi_bound);
        hit_d.attr  = attr_en && (((op_attr ^ attr_match) & ~attr_mask) == '0);
        hit_d.pcm   = pc_eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= '0;
        end else begin
            hit_q <= hit_d;
        end
    end

    assign range_hit  = hit_q.range;
    assign attr_hit   = hit_q.attr;
    assign pc_hit_vec = hit_q.pcm;

endmodule

// File: rtl/dbg_bkpt_bank.sv
module dbg_bkpt_bank
    import dbg_bkpt_pkg::*;
#(
    parameter int NUM_PC = 4,
    parameter int ATTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cmd_valid,
    input  logic              host_cmd_write,
    input  logic [4:0]        host_cmd_idx,
    input  logic [31:0]       host_cmd_wdata,
    output logic              host_rsp_valid,
    output logic [31:0]       host_rsp_data,
    input  logic              cpu_wr_en,
    input  logic              cpu_supervisor,
    input  logic [4:0]        cpu_wr_idx,
    input  logic [31:0]       cpu_wr_data,
    input  logic [31:0]       op_addr,
    input  logic [ATTR_W-1:0] op_attr,
    input  logic [31:0]       pc,
    output logic              range_hit,
    output logic              attr_hit,
    output logic              pc_hit,
    output logic [NUM_PC-1:0] pc_hit_vec
);

    wr_req_t                  host_wr_w;
    wr_req_t                  cpu_wr_w;
    logic [IDX_W-1:0]         rd_idx_w;
    logic [DATA_W-1:0]        rd_data_w;
    logic                     lock_w;
    logic                     range_en_w;
    logic                     attr_en_w;
    logic [DATA_W-1:0]        lo_w;
    logic [DATA_W-1:0]        hi_w;
    logic [ATTR_W-1:0]        amatch_w;
    logic [ATTR_W-1:0]        amask_w;
    logic [NUM_PC-1:0]        pcv_w;
    logic [NUM_PC*DATA_W-1:0] pbr_w;

    dbg_host_port i_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (host_cmd_valid),
        .cmd_write (host_cmd_write),
        .cmd_idx   (host_cmd_idx),
        .cmd_wdata (host_cmd_wdata),
        .rd_data   (rd_data_w),
        .rd_idx    (rd_idx_w),
        .host_wr   (host_wr_w),
        .rsp_valid (host_rsp_valid),
        .rsp_data  (host_rsp_data)
    );

    dbg_cpu_port i_cpu (
        .wr_en      (cpu_wr_en),
        .supervisor (cpu_supervisor),
        .wr_idx     (cpu_wr_idx),
        .wr_data    (cpu_wr_data),
        .lock       (lock_w),
        .cpu_wr     (cpu_wr_w)
    );

    dbg_reg_file #(.NUM_PC(NUM_PC), .ATTR_W(ATTR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr_w),
        .cpu_wr     (cpu_wr_w),
        .rd_idx     (rd_idx_w),
        .rd_data    (rd_data_w),
        .lock       (lock_w),
        .range_en   (range_en_w),
        .attr_en    (attr_en_w),
        .lo_bound   (lo_w),
        .hi_bound   (hi_w),
        .attr_match (amatch_w),
        .attr_mask  (amask_w),
        .pc_valid   (pcv_w),
        .pc_bkpt    (pbr_w)
    );

    dbg_match #(.NUM_PC(NUM_PC), .ATTR_W(ATTR_W)) i_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .range_en   (range_en_w),
        .attr_en    (attr_en_w),
        .lo_bound   (lo_w),
        .hi_bound   (hi_w),
        .attr_match (amatch_w),
        .attr_mask  (amask_w),
        .pc_valid   (pcv_w),
        .pc_bkpt    (pbr_w),
        .op_addr    (op_addr),
        .op_attr    (op_attr),
        .pc         (pc),
        .range_hit  (range_hit),
        .attr_hit   (attr_hit),
        .pc_hit_vec (pc_hit_vec)
    );

    assign pc_hit = |pc_hit_vec;

endmodule

// File: rtl/dbg_bkpt_bank_chk.sv
module dbg_bkpt_bank_chk #(
    parameter int NUM_PC = 4,
    parameter int ATTR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_cmd_valid,
    input logic                 host_cmd_write,
    input logic                 host_rsp_valid,
    input logic [31:0]          host_rsp_data,
    input logic                 cpu_wr_en,
    input logic                 range_hit,
    input logic                 attr_hit,
    input logic                 pc_hit,
    input logic                 lock,
    input logic                 range_en,
    input logic                 attr_en,
    input logic [31:0]          lo_b,
    input logic [31:0]          hi_b,
    input logic [ATTR_W-1:0]    amatch,
    input logic [ATTR_W-1:0]    amask,
    input logic [NUM_PC-1:0]    pcv,
    input logic [NUM_PC*32-1:0] pbr
);

    logic [NUM_PC*32+2*ATTR_W+NUM_PC+66:0] bank_img;
    assign bank_img = {lock, range_en, attr_en, lo_b, hi_b, amatch, amask, pcv, pbr};

    p_rsp_follows_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_cmd_valid |=> host_rsp_valid);

    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cmd_valid |=> !host_rsp_valid);

    p_write_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_valid && host_cmd_write) |=> (host_rsp_data == 32'h0000FFFF));

    p_locked_cpu_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && cpu_wr_en && !(host_cmd_valid && host_cmd_write)) |=> $stable(bank_img));

    p_range_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        range_hit |-> $past(range_en));

    p_attr_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        attr_hit |-> $past(attr_en));

    p_pc_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hit |-> $past(pcv != '0));

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!range_hit && !attr_hit && !pc_hit && !host_rsp_valid));

endmodule

bind dbg_bkpt_bank dbg_bkpt_bank_chk #(.NUM_PC(NUM_PC), .ATTR_W(ATTR_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_cmd_valid (host_cmd_valid),
    .host_cmd_write (host_cmd_write),
    .host_rsp_valid (host_rsp_valid),
    .host_rsp_data  (host_rsp_data),
    .cpu_wr_en      (cpu_wr_en),
    .range_hit      (range_hit),
    .attr_hit       (attr_hit),
    .pc_hit         (pc_hit),
    .lock           (lock_w),
    .range_en       (range_en_w),
    .attr_en        (attr_en_w),
    .lo_b           (lo_w),
    .hi_b           (hi_w),
    .amatch         (amatch_w),
    .amask          (amask_w),
    .pcv            (pcv_w),
    .pbr            (pbr_w)
);

// File: tb/test_dbg_bkpt_bank.sv
module test_dbg_bkpt_bank;

    localparam int NUM_PC = 4;
    localparam int ATTR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_cmd_valid = 1'b0;
    logic              host_cmd_write = 1'b0;
    logic [4:0]        host_cmd_idx = '0;
    logic [31:0]       host_cmd_wdata = '0;
    logic              host_rsp_valid;
    logic [31:0]       host_rsp_data;
    logic              cpu_wr_en = 1'b0;
    logic              cpu_supervisor = 1'b0;
    logic [4:0]        cpu_wr_idx = '0;
    logic [31:0]       cpu_wr_data = '0;
    logic [31:0]       op_addr = '0;
    logic [ATTR_W-1:0] op_attr = '0;
    logic [31:0]       pc = '0;
    logic              range_hit;
    logic              attr_hit;
    logic              pc_hit;
    logic [NUM_PC-1:0] pc_hit_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_bkpt_bank #(.NUM_PC(NUM_PC), .ATTR_W(ATTR_W)) i_dbg_bkpt_bank (
        .clk(clk), .rst_n(rst_n),
        .host_cmd_valid(host_cmd_valid), .host_cmd_write(host_cmd_write),
        .host_cmd_idx(host_cmd_idx), .host_cmd_wdata(host_cmd_wdata),
        .host_rsp_valid(host_rsp_valid), .host_rsp_data(host_rsp_data),
        .cpu_wr_en(cpu_wr_en), .cpu_supervisor(cpu_supervisor),
        .cpu_wr_idx(cpu_wr_idx), .cpu_wr_data(cpu_wr_data),
        .op_addr(op_addr), .op_attr(op_attr), .pc(pc),
        .range_hit(range_hit), .attr_hit(attr_hit),
        .pc_hit(pc_hit), .pc_hit_vec(pc_hit_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Implemented-bit mask per index, from the register map
    function automatic logic [31:0] impl_mask(input int idx);
        if (idx == 0) return 32'h1;
        if (idx == 1) return 32'h3;
        if (idx == 2 || idx == 3) return 32'hFFFF_FFFF;
        if (idx == 4) return ((32'h1 << ATTR_W) - 1) | (((32'h1 << ATTR_W) - 1) << 16);
        if (idx == 7) return (32'h1 << NUM_PC) - 1;
        if (idx >= 8 && idx < 8 + NUM_PC) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    task automatic host_wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        host_cmd_valid = 1'b1; host_cmd_write = 1'b1;
        host_cmd_idx = 5'(idx); host_cmd_wdata = d;
        @(negedge clk);
        host_cmd_valid = 1'b0; host_cmd_write = 1'b0;
        chk("R1 write rsp valid", 32'(host_rsp_valid), 32'h1);
        chk("R2 write status", host_rsp_data, 32'h0000FFFF);
    endtask

    task automatic host_rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        host_cmd_valid = 1'b1; host_cmd_write = 1'b0; host_cmd_idx = 5'(idx);
        @(negedge clk);
        host_cmd_valid = 1'b0;
        chk("R1 read rsp valid", 32'(host_rsp_valid), 32'h1);
        d = host_rsp_data;
    endtask

    task automatic cpu_wr(input int idx, input logic [31:0] d, input bit sup);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_supervisor = sup; cpu_wr_idx = 5'(idx); cpu_wr_data = d;
        @(negedge clk);
        cpu_wr_en = 1'b0; cpu_supervisor = 1'b0;
    endtask

    task automatic expect_reg(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        host_rd(idx, v);
        chk(req, v, exp);
    endtask

    task automatic probe(input logic [31:0] a, input logic [ATTR_W-1:0] at, input logic [31:0] p);
        @(negedge clk);
        op_addr = a; op_attr = at; pc = p;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [2];
        logic [31:0] lo_v, hi_v, a;
        logic [ATTR_W-1:0] m, mk;
        logic [31:0] addrs [8];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'hA5C3_5A3C;

        repeat (3) @(negedge clk);
        // R10: reset state on the outputs
        chk("R10 rsp idle", 32'(host_rsp_valid), 32'h0);
        chk("R10 hits idle", {29'b0, range_hit, attr_hit, pc_hit}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 hits idle after release", {29'b0, range_hit, attr_hit, pc_hit}, 32'h0);
        for (int i = 0; i < 32; i++) expect_reg("R10 register zero", i, 32'h0);
        probe(32'h0, '0, 32'h0);
        chk("R10 no hit with zero config", {29'b0, range_hit, attr_hit, pc_hit}, 32'h0);

        // R1/R3: write and read back every index with two patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 32; i++) begin
                if (i == 0) continue;
                host_wr(i, pats[p]);
                expect_reg("R1 R3 readback", i, pats[p] & impl_mask(i));
            end
        end
        // CSR readback, then clear it again
        host_wr(0, 32'hFFFF_FFFE);
        expect_reg("R3 csr bit0 only", 0, 32'h0);
        host_wr(0, 32'h0000_0003);
        expect_reg("R1 csr lock set", 0, 32'h1);
        host_wr(0, 32'h0);
        for (int i = 0; i < 32; i++) host_wr(i, 32'h0);

        // R4: supervisor processor write with lock clear
        cpu_wr(2, 32'h1234_5678, 1'b1);
        expect_reg("R4 cpu write lower", 2, 32'h1234_5678);
        cpu_wr(9, 32'hCAFE_0004, 1'b1);
        expect_reg("R4 cpu write pbr1", 9, 32'hCAFE_0004);
        cpu_wr(6, 32'hFFFF_FFFF, 1'b1);
        expect_reg("R3 cpu unmapped", 6, 32'h0);

        // R5: user mode ignored, CSR unwritable, lock blocks
        cpu_wr(2, 32'h1111_1111, 1'b0);
        expect_reg("R5 user write ignored", 2, 32'h1234_5678);
        cpu_wr(0, 32'h1, 1'b1);
        expect_reg("R5 cpu cannot set lock", 0, 32'h0);
        host_wr(0, 32'h1);
        cpu_wr(2, 32'h2222_2222, 1'b1);
        expect_reg("R5 locked write ignored", 2, 32'h1234_5678);
        cpu_wr(0, 32'h0, 1'b1);
        expect_reg("R5 cpu cannot clear lock", 0, 32'h1);
        host_wr(3, 32'h3333_3333);
        expect_reg("R5 host passes lock", 3, 32'h3333_3333);
        host_wr(0, 32'h0);

        // R6: same-cycle collision, host wins
        @(negedge clk);
        host_cmd_valid = 1'b1; host_cmd_write = 1'b1; host_cmd_idx = 5'd3; host_cmd_wdata = 32'hAAAA_0000;
        cpu_wr_en = 1'b1; cpu_supervisor = 1'b1; cpu_wr_idx = 5'd3; cpu_wr_data = 32'hBBBB_0000;
        @(negedge clk);
        host_cmd_valid = 1'b0; host_cmd_write = 1'b0; cpu_wr_en = 1'b0; cpu_supervisor = 1'b0;
        chk("R6 collision rsp", host_rsp_data, 32'h0000FFFF);
        expect_reg("R6 host value kept", 3, 32'hAAAA_0000);

        // R7: range compare at the boundaries, enabled and disabled
        lo_v = 32'h0000_0100; hi_v = 32'h8000_01FF;
        host_wr(2, lo_v); host_wr(3, hi_v);
        addrs[0] = 32'h0; addrs[1] = 32'hFF; addrs[2] = 32'h100; addrs[3] = 32'h101;
        addrs[4] = 32'h8000_01FE; addrs[5] = 32'h8000_01FF; addrs[6] = 32'h8000_0200; addrs[7] = 32'hFFFF_FFFF;
        for (int e = 0; e < 2; e++) begin
            host_wr(1, 32'(e));
            for (int k = 0; k < 8; k++) begin
                a = addrs[k];
                probe(a, '0, 32'h0);
                chk("R7 range hit", 32'(range_hit), 32'((e == 1) && (a >= lo_v) && (a <= hi_v)));
            end
        end
        host_wr(1, 32'h0);

        // R8: exhaustive attribute sweep with a partial mask
        m = 8'hA5; mk = 8'h0F;
        host_wr(4, {8'h0, mk, 8'h0, m});
        host_wr(1, 32'h2);
        for (int x = 0; x < (1 << ATTR_W); x++) begin
            probe(32'h0, ATTR_W'(x), 32'h0);
            chk("R8 attr hit", 32'(attr_hit), 32'(((ATTR_W'(x) ^ m) & ~mk) == '0));
        end
        host_wr(1, 32'h1 << 0);
        probe(32'h0, m, 32'h0);
        chk("R8 attr disabled", 32'(attr_hit), 32'h0);
        host_wr(1, 32'h0);

        // R9: every valid-bit combination against every breakpoint address
        for (int i = 0; i < NUM_PC; i++) host_wr(8 + i, 32'h0000_1000 + 32'(i) * 4);
        for (int vb = 0; vb < (1 << NUM_PC); vb++) begin
            host_wr(7, 32'(vb));
            for (int t = 0; t <= NUM_PC; t++) begin
                logic [NUM_PC-1:0] ev;
                ev = '0;
                if (t < NUM_PC) ev[t] = vb[t];
                probe(32'h0, '0, 32'h0000_1000 + 32'(t) * 4);
                chk("R9 pc hit vec", 32'(pc_hit_vec), 32'(ev));
                chk("R9 pc hit any", 32'(pc_hit), 32'(|ev));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule